// File: doc/BRIEF.md
# Fractional Gain Scaler with Round-Half-Up

This block scales an unsigned whole-number sample by an unsigned gain that is always strictly less than one, and returns a rounded whole number as wide as the sample. The sample carries only integer bits, and the gain carries only fraction bits, with its binary point just above its top bit. Because of this, a narrow width-by-width multiplier is enough, and its double-width product already holds integer and fraction fields of equal size. No shift or divide is needed. The block adds one half of an output LSB to the product and keeps only the upper half, which gives round-to-nearest with ties going up.

A single register stage holds the result. A qualifier input marks operand cycles. The output qualifier follows it exactly one clock later, and the result register loads only on qualified cycles. A synchronous active-high reset clears both registers.

Top module: `gain_scaler`

## Requirements
- R1: For W-bit sample s and W-bit gain code g (gain value g / 2^W), a qualified cycle yields result_out = floor((s*g + 2^(W-1)) / 2^W) on the following clock.
- R2: A product whose fraction field is exactly one half (top fraction bit set, all others clear) rounds up. Examples: W=8, s=3, g=0x80 gives 2; W=4, s=5, g=8 gives 3.
- R3: The rounding add never carries out of the W-bit integer field, and every result is no greater than the sample that produced it.
- R4: valid_out is high in exactly those cycles that follow a cycle with valid_in high and reset low.
- R5: While valid_in is low, result_out keeps its last value, whatever the operand inputs do.
- R6: A synchronous active-high reset clears valid_out and result_out on the next clock. Reset takes priority over a qualified operand presented in the same cycle.
- R7: A zero gain or a zero sample gives a result of zero.
- R8: With W=4, a sample of 15 and a gain code of 15 (value 0.9375) give 14.
- R9: With W=8, the largest operands (255 and 255) give 254.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| valid_in | input | 1 | Operands on this cycle are to be scaled |
| sample_in | input | W | Unsigned whole-number sample |
| gain_in | input | W | Unsigned pure-fraction gain code |
| valid_out | output | 1 | result_out holds a fresh result |
| result_out | output | W | Rounded scaled sample |

## Verification
Two events can meet in the same cycle: a qualified operand and a reset, and a rounding increment and the upper edge of the integer field. The bench asserts reset while valid_in is high with large operands, and expects both outputs to read zero on the next clock. It also drives maximal samples with gains whose fraction field sits at or above one half, so the increment ripples through the integer field. The result must equal the computed reference, and the bound checker must see no carry out.

// File: rtl/gain_scaler_pkg.sv
package gain_scaler_pkg;

    localparam int unsigned GSC_DEFAULT_W = 8;

    function automatic int unsigned gsc_prod_w(input int unsigned w);
        return 2 * w;
    endfunction

    function automatic int unsigned gsc_sum_w(input int unsigned w);
        return 2 * w + 1;
    endfunction

endpackage

// File: rtl/gsc_mult.sv
module gsc_mult #(
    parameter int unsigned W = gain_scaler_pkg::GSC_DEFAULT_W,
    localparam int unsigned PW = gain_scaler_pkg::gsc_prod_w(W)
) (
    input  logic [W-1:0]  whole_i,
    input  logic [W-1:0]  frac_i,
    output logic [PW-1:0] prod_o
);
    // Integer-only times fraction-only: upper W bits are integer, lower W are fraction.
    always_comb begin
        prod_o = PW'(whole_i) * PW'(frac_i);
    end
endmodule

// File: rtl/gsc_round.sv
module gsc_round #(
    parameter int unsigned W = gain_scaler_pkg::GSC_DEFAULT_W,
    localparam int unsigned PW = gain_scaler_pkg::gsc_prod_w(W),
    localparam int unsigned SW = gain_scaler_pkg::gsc_sum_w(W)
) (
    input  logic [PW-1:0] prod_i,
    output logic [W-1:0]  int_o,
    output logic          carry_o
);
    localparam logic [SW-1:0] HALF_LSB = SW'(1) << (W - 1);

    typedef struct packed {
        logic         carry;
        logic [W-1:0] whole;
        logic [W-1:0] frac;
    } sum_t;

    sum_t sum;

    always_comb begin
        sum     = sum_t'({1'b0, prod_i} + HALF_LSB);
        int_o   = sum.whole;
        carry_o = sum.carry;
    end
endmodule

// File: rtl/gain_scaler.sv
module gain_scaler #(
    parameter int unsigned W = gain_scaler_pkg::GSC_DEFAULT_W
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         valid_in,
    input  logic [W-1:0] sample_in,
    input  logic [W-1:0] gain_in,
    output logic         valid_out,
    output logic [W-1:0] result_out
);
    localparam int unsigned PW = gain_scaler_pkg::gsc_prod_w(W);

    typedef struct packed {
        logic         vld;
        logic [W-1:0] val;
    } stage_t;

    logic [PW-1:0] product;
    logic [W-1:0]  rounded;
    logic          round_carry;
    stage_t        stage_q;

    gsc_mult #(.W(W)) mult_i (
        .whole_i (sample_in),
        .frac_i  (gain_in),
        .prod_o  (product)
    );

    gsc_round #(.W(W)) round_i (
        .prod_i  (product),
        .int_o   (rounded),
        .carry_o (round_carry)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            stage_q <= '0;
        end else begin
            stage_q.vld <= valid_in;
            if (valid_in) begin
                stage_q.val <= rounded;
            end
        end
    end

    assign valid_out  = stage_q.vld;
    assign result_out = stage_q.val;
endmodule

// File: rtl/gain_scaler_chk.sv
module gain_scaler_chk #(
    parameter int unsigned W = 8
) (
    input logic         clk,
    input logic         rst,
    input logic         valid_in,
    input logic [W-1:0] sample_in,
    input logic [W-1:0] gain_in,
    input logic         valid_out,
    input logic [W-1:0] result_out,
    input logic         carry_seen
);
    // R3
    no_overflow_chk: assert property (@(posedge clk) disable iff (rst)
        valid_in |-> !carry_seen);

    // R3
    result_bound_chk: assert property (@(posedge clk) disable iff (rst)
        valid_in |=> (result_out <= $past(sample_in)));

    // R4
    valid_follow_chk: assert property (@(posedge clk) disable iff (rst)
        valid_in |=> valid_out);

    // R4
    valid_idle_chk: assert property (@(posedge clk) disable iff (rst)
        !valid_in |=> !valid_out);

    // R5
    hold_chk: assert property (@(posedge clk) disable iff (rst)
        !valid_in |=> $stable(result_out));

    // R6
    reset_clear_chk: assert property (@(posedge clk)
        rst |=> (!valid_out && result_out == '0));

    // R7
    zero_gain_chk: assert property (@(posedge clk) disable iff (rst)
        (valid_in && gain_in == '0) |=> (result_out == '0));
endmodule

bind gain_scaler gain_scaler_chk #(.W(W)) chk_i (
    .clk        (clk),
    .rst        (rst),
    .valid_in   (valid_in),
    .sample_in  (sample_in),
    .gain_in    (gain_in),
    .valid_out  (valid_out),
    .result_out (result_out),
    .carry_seen (round_carry)
);

// File: tb/gain_scaler_tb_top.sv
`timescale 1ns/1ps
module gain_scaler_tb_top;
    logic clk = 1'b0;
    logic rst = 1'b1;
    logic vin = 1'b0;
    logic [7:0] s8 = '0, g8 = '0, r8;
    logic [3:0] s4 = '0, g4 = '0, r4;
    logic v8, v4;
    int n_vec = 0;
    int n_fail = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    gain_scaler #(.W(8)) dut_i (
        .clk(clk), .rst(rst), .valid_in(vin), .sample_in(s8), .gain_in(g8),
        .valid_out(v8), .result_out(r8));

    gain_scaler #(.W(4)) dut4_i (
        .clk(clk), .rst(rst), .valid_in(vin), .sample_in(s4), .gain_in(g4),
        .valid_out(v4), .result_out(r4));

    function automatic int ref_scale(input int w, input int s, input int g);
        return (s * g + (1 << (w - 1))) >> w;
    endfunction

    task automatic check(input string req, input int act, input int exp);
        n_vec++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // Present operands at a falling edge, then sample after the next rising edge.
    task automatic step(input logic v, input int a8, input int b8, input int a4, input int b4);
        vin = v; s8 = 8'(a8); g8 = 8'(b8); s4 = 4'(a4); g4 = 4'(b4);
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic both(input string req, input int a8, input int b8, input int a4, input int b4);
        step(1'b1, a8, b8, a4, b4);
        check({req, " w8"}, int'(r8), ref_scale(8, a8, b8));
        check({req, " w4"}, int'(r4), ref_scale(4, a4, b4));
        check({req, " valid"}, int'(v8 & v4), 1);
    endtask

    initial begin
        void'($urandom(32'd20240611));
        repeat (3) @(negedge clk);
        // R6 reset state
        check("R6 reset valid", int'(v8 | v4), 0);
        check("R6 reset result", int'(r8) + int'(r4), 0);
        rst = 1'b0;

        // R1 R4: exhaustive W=4 sweep alongside random W=8 traffic
        for (int a = 0; a < 16; a++) begin
            for (int b = 0; b < 16; b++) begin
                both("R1", int'($urandom_range(255)), int'($urandom_range(255)), a, b);
            end
        end
        for (int k = 0; k < 1500; k++) begin
            both("R1", int'($urandom_range(255)), int'($urandom_range(255)),
                 int'($urandom_range(15)), int'($urandom_range(15)));
        end

        // R2 ties round up
        step(1'b1, 3, 8'h80, 5, 8);
        check("R2 tie w8", int'(r8), 2);
        check("R2 tie w4", int'(r4), 3);
        step(1'b1, 1, 8'h80, 1, 8);
        check("R2 tie unit w8", int'(r8), 1);
        check("R2 tie unit w4", int'(r4), 1);

        // R8 and R9: top-end operands, increment ripples near the field edge
        step(1'b1, 255, 255, 15, 15);
        check("R9 max w8", int'(r8), 254);
        check("R8 15x15/16 w4", int'(r4), 14);
        // R3 results never exceed the sample
        for (int k = 0; k < 200; k++) begin
            int a = 255 - int'($urandom_range(3));
            int b = 128 + int'($urandom_range(127));
            step(1'b1, a, b, 15, 8 + int'($urandom_range(7)));
            check("R3 bound w8", int'(r8 <= 8'(a)), 1);
            check("R3 ref w8", int'(r8), ref_scale(8, a, b));
        end

        // R7 zero operands
        step(1'b1, 200, 0, 15, 0);
        check("R7 zero gain w8", int'(r8), 0);
        check("R7 zero gain w4", int'(r4), 0);
        step(1'b1, 0, 255, 0, 15);
        check("R7 zero sample w8", int'(r8), 0);
        check("R7 zero sample w4", int'(r4), 0);

        // R5 hold while unqualified
        both("R1", 100, 200, 9, 11);
        step(1'b0, 255, 255, 15, 15);
        check("R5 hold w8", int'(r8), ref_scale(8, 100, 200));
        check("R5 hold w4", int'(r4), ref_scale(4, 9, 11));
        check("R4 idle valid", int'(v8 | v4), 0);
        step(1'b0, 17, 3, 2, 2);
        check("R5 hold again w8", int'(r8), ref_scale(8, 100, 200));
        both("R4", 77, 99, 6, 13);

        // R6 reset beats a qualified operand in the same cycle
        rst = 1'b1;
        step(1'b1, 250, 250, 14, 14);
        check("R6 priority valid", int'(v8 | v4), 0);
        check("R6 priority result", int'(r8) + int'(r4), 0);
        rst = 1'b0;
        both("R4", 250, 250, 14, 14);

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
        $finish;
    end

    initial begin
        #1_000_000;
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
            $finish;
        end
    end
endmodule